// File: doc/BRIEF.md
# Programmable Binary-Weighted Delay Line

The block delays a data word by a programmable number of clock cycles, from zero up to sixty-three. Storage is split into six shift-register segments whose lengths are the powers of two from one to thirty-two. The segments are chained from the shortest, next to the input, to the longest, next to the output. A two-way selector after each segment either takes that segment's output or passes its input around it. Each selector is steered by one bit of the delay control word, so the total latency is the sum of the lengths of the segments that are switched in.

All segments shift on every clock, whether or not they are in the path. The delay control may change while data flows. The output then switches at once to whatever the newly chosen path holds, with no effort to make the handover clean. A delay of zero gives a purely combinational path from input to output. An active-low asynchronous reset clears every stage.

Top module: `tdl_top`

## Requirements
- R1: With the delay control `dly_i` held at value d (read as an unsigned number, 0 to 63) for at least 63 cycles, `dout_o` equals the `din_i` word that was captured d rising clock edges earlier. This holds for all 64 values of d.
- R2: With `dly_i` equal to 0, `dout_o` follows `din_i` combinationally in the same cycle, without waiting for a clock edge.
- R3: Bypassed segments keep shifting. After `dly_i` has been 0 for at least 32 cycles, changing it to 32 (only bit 5 set) makes `dout_o` equal, in that same cycle, to the input from 32 edges earlier.
- R4: While `rst_ni` is low, every stage holds zero, so `dout_o` is 0 for any nonzero delay. After reset is released, history from before the release reads as zero.
- R5: A change of `dly_i` takes effect in the cycle it is applied, and no stage is cleared. After a long run at 63, switching to 1 (bit 0, the 1-stage segment) gives the input from one edge earlier.
- R6: Control bit k selects a segment of 2^k stages, and the segments are chained in ascending length from the input. After a long run at 63, switching to 32 gives the input from 63 edges earlier in the first cycle, because the 32-stage segment was fed through the other five.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | DATA_W | Data word entering the line |
| dly_i | input | NUM_SEG | Delay in cycles; bit k switches in the 2^k-stage segment |
| dout_o | output | DATA_W | Delayed data word |

## Verification
A stage that is stuck or skipped, or a segment of the wrong length, shows up at `dout_o` as a word from the wrong age. This appears as soon as the delay setting routes through the faulty segment and that segment has filled, at most 63 cycles later. A fault in the order of the segments, or a segment that stops shifting while it is bypassed, is invisible while the delay is held constant. It shows up only in the first cycle after the setting changes, so the switch-over cases compare that exact cycle against the ideal history. Every setting is compared on each clock against an input history kept in the bench.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int DEF_DATA_W  = 8;
  localparam int DEF_NUM_SEG = 6;

  function automatic int seg_len(input int k);
    return 1 << k;
  endfunction
endpackage

// File: rtl/tdl_segment.sv
module tdl_segment #(
  parameter int W   = 8,
  parameter int LEN = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [LEN-1:0][W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int i = 1; i < LEN; i++) sr_q[i] <= sr_q[i-1];
    end
  end

  assign q_o = sr_q[LEN-1];
endmodule

// File: rtl/tdl_bypass.sv
module tdl_bypass #(
  parameter int W = 8
) (
  input  logic         sel_i,
  input  logic [W-1:0] thru_i,
  input  logic [W-1:0] seg_i,
  output logic [W-1:0] y_o
);
  always_comb y_o = sel_i ? seg_i : thru_i;
endmodule

// File: rtl/tdl_top.sv
module tdl_top #(
  parameter int DATA_W  = tdl_pkg::DEF_DATA_W,
  parameter int NUM_SEG = tdl_pkg::DEF_NUM_SEG
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] din_i,
  input  logic [NUM_SEG-1:0] dly_i,
  output logic [DATA_W-1:0] dout_o
);
  // chain_w[k] feeds segment k; chain_w[NUM_SEG] is the line output
  logic [NUM_SEG:0][DATA_W-1:0]  chain_w;
  logic [NUM_SEG-1:0][DATA_W-1:0] seg_w;

  assign chain_w[0] = din_i;

  for (genvar k = 0; k < NUM_SEG; k++) begin : g_seg
    tdl_segment #(.W(DATA_W), .LEN(tdl_pkg::seg_len(k))) u_seg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (chain_w[k]),
      .q_o   (seg_w[k])
    );
    tdl_bypass #(.W(DATA_W)) u_byp (
      .sel_i (dly_i[k]),
      .thru_i(chain_w[k]),
      .seg_i (seg_w[k]),
      .y_o   (chain_w[k+1])
    );
  end

  assign dout_o = chain_w[NUM_SEG];
endmodule

// File: rtl/tdl_checks.sv
module tdl_checks #(
  parameter int DATA_W  = 8,
  parameter int NUM_SEG = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] din_i,
  input logic [NUM_SEG-1:0] dly_i,
  input logic [DATA_W-1:0] dout_o
);
  logic [1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assert_zero_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dly_i == '0) |-> (dout_o == din_i));

  // stage 0 shifts whatever the earlier setting was (R3)
  assert_one_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd1 && dly_i == NUM_SEG'(1)) |-> (dout_o == $past(din_i)));

  assert_two_cycle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && dly_i == NUM_SEG'(2) && $past(dly_i) == NUM_SEG'(2)
     && $past(dly_i, 2) == NUM_SEG'(2)) |-> (dout_o == $past(din_i, 2)));

  assert_reset_zero_R4: assert property (@(posedge clk_i)
    (!rst_ni && dly_i != '0) |-> (dout_o == '0));
endmodule

bind tdl_top tdl_checks #(.DATA_W(DATA_W), .NUM_SEG(NUM_SEG)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .din_i (din_i),
  .dly_i (dly_i),
  .dout_o(dout_o)
);

// File: tb/tdl_top_tb.sv
module tdl_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] din = '0;
  logic [5:0]   dly = 6'd5;
  logic [W-1:0] dout;

  logic [W-1:0] hist [128];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdl_top u_dut (
    .clk_i (clk),
    .rst_ni(rst_ni),
    .din_i (din),
    .dly_i (dly),
    .dout_o(dout)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%0h expected=%0h (dly=%0d)", req, act, exp, dly);
    end
  endtask

  // one cycle: new delay and input at the falling edge, history shifted
  task automatic step(input int d, input logic [W-1:0] v);
    @(negedge clk);
    for (int i = 127; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = v;
    dly = 6'(d);
    din = v;
    #1;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) hist[i] = '0;
    din = 8'hAA;
    #1;
    repeat (3) @(negedge clk);
    #1;
    check("R4 reset clears stages", dout, 8'h00);
    dly = 6'd0;
    #1;
    check("R2 passthru in reset", dout, 8'hAA);
    dly = 6'd63;
    @(negedge clk);
    rst_ni = 1'b1;

    for (int j = 0; j < 5; j++) begin
      step(63, W'($urandom));
      check("R4 pre-reset history zero", dout, 8'h00);
    end

    for (int d = 0; d < 64; d++) begin
      for (int j = 0; j < 63; j++) step(d, W'($urandom));
      for (int j = 0; j < 8; j++) begin
        step(d, W'($urandom));
        check("R1 constant delay", dout, hist[d]);
      end
    end

    step(0, 8'h3C);
    check("R2 zero delay", dout, 8'h3C);
    din = 8'hC3;
    #1;
    check("R2 combinational follow", dout, 8'hC3);
    hist[0] = 8'hC3;

    for (int j = 0; j < 40; j++) step(0, W'($urandom));
    step(32, W'($urandom));
    check("R3 bypassed segment shifted", dout, hist[32]);

    for (int j = 0; j < 70; j++) step(63, W'($urandom));
    step(1, W'($urandom));
    check("R5 switch 63 to 1", dout, hist[1]);

    for (int j = 0; j < 70; j++) step(63, W'($urandom));
    step(32, W'($urandom));
    check("R6 ascending cascade", dout, hist[63]);
    step(32, W'($urandom));
    check("R6 ascending cascade next", dout, hist[63]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule